// File: doc/BRIEF.md
# Cache Line Fill State Unit

This block sits on the return path of a set-associative cache. When a fill response comes back from the next level, the block decides where the line goes and which state bits it ends with. The line can go into the way that already holds it, into a victim way picked elsewhere, or into a single temporary line buffer. The state bits are valid, readable, writable and dirty. The block also raises the full-line data write and stamps the cycle at which the line's data may be used.

Response attributes, the tag lookup result and the victim choice are presented for one cycle with `fill_valid`. All results appear registered on the next cycle, qualified by `upd_valid`.

State bits are decided with sharers taken first. A response that reports other sharers never grants write permission, and any peer-supplied flag is disregarded, so a freshly filled line is Shared, Exclusive or Modified and never Owned. A fill that may not take a way in the array is still completed, in the temporary buffer.

Top module: `fill_state_unit`

## Requirements
- R1: While reset is held, `upd_valid`, `line_we` and `use_temp` are 0 and `cycle_now` is 0.
- R2: Every accepted fill produces a line state with valid and readable both set (state bit order: [3] valid, [2] readable, [1] writable, [0] dirty).
- R3: A fill reporting no sharers sets writable. If it also reports that a peer cache supplied the data, it sets dirty too.
- R4: A fill reporting sharers on a tag miss ends in state 4'b1100 whatever the peer-supplied flag says. The peer-supplied flag can set dirty only when no sharers are reported.
- R5: A fill that misses the tags, asks for allocation and has a replaceable victim is placed in `victim_way`, with `use_temp` 0.
- R6: A fill that misses without allocation, or whose victim is not replaceable, sets `use_temp` and starts from an empty state.
- R7: A fill that hits keeps the existing line's bits, including dirty, adds the bits granted by the response, and reports `lookup_way`.
- R8: A read fill writes the data only when it carries data with a byte count of exactly one line (32 bytes by default). It then raises `line_we` with the response data. A read with any other size is rejected in the same way as an error.
- R9: `ready_time` equals the value of `cycle_now` in the cycle the response was presented, plus FILL_LAT, plus the header delay, plus the payload delay. It saturates and is never below that issue cycle.
- R10: A clean response without invalidate that hits a valid line returns the existing state with readable set and writes no data. On a miss it returns an empty state with no buffer use.
- R11: An error response writes no data, uses no buffer, and returns the lookup state unchanged on a hit, or an empty state on a miss.
- R12: An invalidate-only response without data may allocate a line without writing data. It must report no sharers, so the line becomes writable.
- R13: `upd_valid` is high exactly in the cycle after each cycle with `fill_valid` high, and low otherwise.
- R14: `upd_addr` is the response address with the line offset bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Response attributes are presented this cycle |
| rsp_has_data | input | 1 | Response carries data |
| rsp_is_read | input | 1 | Response answers a read |
| rsp_sharers | input | 1 | Other caches keep copies |
| rsp_peer_supplied | input | 1 | Data came from a peer cache |
| rsp_invalidate | input | 1 | Response carries invalidation |
| rsp_clean | input | 1 | Response answers a clean operation |
| rsp_error | input | 1 | Response reports an error |
| rsp_bytes | input | BYTES_W (6) | Data byte count |
| rsp_addr | input | ADDR_W (32) | Response address |
| rsp_data | input | LINE_BITS (256) | Full-line data |
| rsp_hdr_dly | input | DLY_W (8) | Header delay in cycles |
| rsp_pay_dly | input | DLY_W (8) | Payload delay in cycles |
| alloc_req | input | 1 | Allocation is wanted on a miss |
| lookup_hit | input | 1 | Tag lookup found the line |
| lookup_way | input | WAY_W (2) | Way of the hit |
| lookup_state | input | 4 | Current state of the hit line |
| victim_ok | input | 1 | A replaceable victim exists |
| victim_way | input | WAY_W (2) | Victim way |
| upd_valid | output | 1 | Results are valid |
| upd_way | output | WAY_W (2) | Target way |
| upd_state | output | 4 | New line state |
| upd_addr | output | ADDR_W (32) | Line-aligned address |
| line_we | output | 1 | Write line data |
| line_data | output | LINE_BITS (256) | Data to write |
| use_temp | output | 1 | Line goes to the temporary buffer |
| ready_time | output | TS_W (32) | Cycle at which the data is usable |
| cycle_now | output | TS_W (32) | Free-running cycle count |

## Verification
On every cycle, the assertions check several properties. No freshly placed line ends dirty without write permission. A data write always carries valid and readable. An error never writes or claims the buffer. An existing dirty bit survives a hit. The ready stamp never precedes the issue cycle, and the cycle count never goes backwards. Invalidate-only fills reporting sharers are flagged as illegal input. The directed scenarios show the exact encodings in each case: the Shared/Exclusive/Modified outcomes, the choice between victim and temporary buffer, the rejection of wrong-size reads, the clean restore, the exact ready arithmetic and the one-cycle output pulse.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef struct packed {
    logic vld;
    logic rd;
    logic wr;
    logic dty;
  } lstate_t;

  typedef enum logic [1:0] {
    PL_NONE   = 2'd0,
    PL_HIT    = 2'd1,
    PL_VICTIM = 2'd2,
    PL_TEMP   = 2'd3
  } place_e;
endpackage

// File: rtl/fill_classify.sv
module fill_classify #(
  parameter int LINE_BYTES = 32,
  parameter int BYTES_W    = 6
) (
  input  logic               is_read,
  input  logic               has_data,
  input  logic [BYTES_W-1:0] bytes,
  input  logic               error,
  input  logic               clean,
  input  logic               inval,
  input  logic               hit,
  input  logic               lookup_vld,
  output logic               do_fill,
  output logic               do_restore,
  output logic               do_write
);
  logic size_ok, reject, clean_only;

  always_comb begin
    size_ok    = !is_read || (has_data && (bytes == BYTES_W'(LINE_BYTES)));
    reject     = error || !size_ok;
    clean_only = clean && !inval;
    do_fill    = !reject && !clean_only;
    do_restore = !reject && clean_only && hit && lookup_vld;
    do_write   = do_fill && is_read;
  end
endmodule

// File: rtl/fill_place.sv
module fill_place
  import fill_pkg::*;
#(
  parameter int WAY_W = 2
) (
  input  logic             do_fill,
  input  logic             hit,
  input  logic [WAY_W-1:0] lookup_way,
  input  logic             alloc_req,
  input  logic             victim_ok,
  input  logic [WAY_W-1:0] victim_way,
  output place_e           place,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    place = PL_NONE;
    way   = '0;
    if (hit) begin
      place = PL_HIT;
      way   = lookup_way;
    end else if (do_fill) begin
      if (alloc_req && victim_ok) begin
        place = PL_VICTIM;
        way   = victim_way;
      end else begin
        place = PL_TEMP;
      end
    end
  end
endmodule

// File: rtl/fill_state_next.sv
module fill_state_next
  import fill_pkg::*;
(
  input  logic    do_fill,
  input  logic    do_restore,
  input  logic    hit,
  input  lstate_t lookup,
  input  logic    sharers,
  input  logic    peer,
  output lstate_t nxt
);
  lstate_t base;

  always_comb begin
    base = hit ? lookup : '0;
    nxt  = base;
    if (do_fill) begin
      nxt.vld = 1'b1;
      nxt.rd  = 1'b1;
      if (!sharers) begin
        nxt.wr = 1'b1;
        if (peer) nxt.dty = 1'b1;
      end
    end else if (do_restore) begin
      nxt.rd = 1'b1;
    end
  end
endmodule

// File: rtl/fill_ready_clock.sv
module fill_ready_clock #(
  parameter int TS_W     = 32,
  parameter int DLY_W    = 8,
  parameter int FILL_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] hdr_dly,
  input  logic [DLY_W-1:0] pay_dly,
  output logic [TS_W-1:0]  now,
  output logic [TS_W-1:0]  ready
);
  localparam int SUM_W = TS_W + 2;
  localparam logic [TS_W-1:0] TS_MAX = '1;

  logic [TS_W-1:0]  now_q, now_d;
  logic [SUM_W-1:0] sum;

  always_comb begin
    now_d = (now_q == TS_MAX) ? now_q : now_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_d;
  end

  always_comb begin
    sum   = SUM_W'(now_q) + SUM_W'(FILL_LAT) + SUM_W'(hdr_dly) + SUM_W'(pay_dly);
    ready = (sum > SUM_W'(TS_MAX)) ? TS_MAX : sum[TS_W-1:0];
  end

  assign now = now_q;

  assert_clock_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    now_q >= $past(now_q));
endmodule

// File: rtl/fill_state_unit.sv
module fill_state_unit
  import fill_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int LINE_BITS = 256,
  parameter int ADDR_W    = 32,
  parameter int TS_W      = 32,
  parameter int DLY_W     = 8,
  parameter int FILL_LAT  = 2,
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LINE_BYTES = LINE_BITS / 8,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int BYTES_W    = OFF_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_valid,
  input  logic                 rsp_has_data,
  input  logic                 rsp_is_read,
  input  logic                 rsp_sharers,
  input  logic                 rsp_peer_supplied,
  input  logic                 rsp_invalidate,
  input  logic                 rsp_clean,
  input  logic                 rsp_error,
  input  logic [BYTES_W-1:0]   rsp_bytes,
  input  logic [ADDR_W-1:0]    rsp_addr,
  input  logic [LINE_BITS-1:0] rsp_data,
  input  logic [DLY_W-1:0]     rsp_hdr_dly,
  input  logic [DLY_W-1:0]     rsp_pay_dly,
  input  logic                 alloc_req,
  input  logic                 lookup_hit,
  input  logic [WAY_W-1:0]     lookup_way,
  input  logic [3:0]           lookup_state,
  input  logic                 victim_ok,
  input  logic [WAY_W-1:0]     victim_way,
  output logic                 upd_valid,
  output logic [WAY_W-1:0]     upd_way,
  output logic [3:0]           upd_state,
  output logic [ADDR_W-1:0]    upd_addr,
  output logic                 line_we,
  output logic [LINE_BITS-1:0] line_data,
  output logic                 use_temp,
  output logic [TS_W-1:0]      ready_time,
  output logic [TS_W-1:0]      cycle_now
);
  lstate_t        lk_state, st_nxt;
  logic           do_fill, do_restore, do_write;
  place_e         place;
  logic [WAY_W-1:0] way_nxt;
  logic [TS_W-1:0]  ready_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  assign lk_state = lstate_t'(lookup_state);

  fill_classify #(.LINE_BYTES(LINE_BYTES), .BYTES_W(BYTES_W)) u_cls (
    .is_read(rsp_is_read), .has_data(rsp_has_data), .bytes(rsp_bytes),
    .error(rsp_error), .clean(rsp_clean), .inval(rsp_invalidate),
    .hit(lookup_hit), .lookup_vld(lk_state.vld),
    .do_fill(do_fill), .do_restore(do_restore), .do_write(do_write)
  );

  fill_place #(.WAY_W(WAY_W)) u_place (
    .do_fill(do_fill), .hit(lookup_hit), .lookup_way(lookup_way),
    .alloc_req(alloc_req), .victim_ok(victim_ok), .victim_way(victim_way),
    .place(place), .way(way_nxt)
  );

  fill_state_next u_state (
    .do_fill(do_fill), .do_restore(do_restore), .hit(lookup_hit),
    .lookup(lk_state), .sharers(rsp_sharers), .peer(rsp_peer_supplied),
    .nxt(st_nxt)
  );

  fill_ready_clock #(.TS_W(TS_W), .DLY_W(DLY_W), .FILL_LAT(FILL_LAT)) u_clk (
    .clk(clk), .rst_n(rst_n), .hdr_dly(rsp_hdr_dly), .pay_dly(rsp_pay_dly),
    .now(cycle_now), .ready(ready_nxt)
  );

  always_comb begin
    addr_nxt = {rsp_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  end

  // valid and write strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      line_we   <= 1'b0;
      use_temp  <= 1'b0;
    end else begin
      upd_valid <= fill_valid;
      line_we   <= fill_valid && do_write;
      use_temp  <= fill_valid && (place == PL_TEMP);
    end
  end

  // payload registers, loaded only with a response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_way    <= '0;
      upd_state  <= '0;
      upd_addr   <= '0;
      line_data  <= '0;
      ready_time <= '0;
    end else if (fill_valid) begin
      upd_way    <= way_nxt;
      upd_state  <= st_nxt;
      upd_addr   <= addr_nxt;
      line_data  <= rsp_data;
      ready_time <= ready_nxt;
    end
  end

  assert_write_has_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_we |-> (upd_state[3] && upd_state[2]));

  assert_never_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !$past(lookup_hit)) |-> !(upd_state[0] && !upd_state[1]));

  assert_keep_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $past(lookup_hit) && $past(lookup_state[0])) |-> upd_state[0]);

  assert_error_no_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $past(rsp_error)) |-> (!line_we && !use_temp));

  assert_ready_not_early_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (ready_time >= $past(cycle_now)));

  assert_inval_only_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && rsp_invalidate && !rsp_has_data && !rsp_error && !rsp_is_read)
      |-> !rsp_sharers);

  assert_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fill_valid) |-> !upd_valid);
endmodule

// File: tb/fill_state_unit_tb_top.sv
module fill_state_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LB = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic fill_valid, has_data, is_read, sharers, peer, inval, clean, err;
  logic [5:0]  bytes;
  logic [31:0] addr;
  logic [LB-1:0] data;
  logic [7:0]  hdr, pay;
  logic alloc, hit, vok;
  logic [1:0] lway, vway;
  logic [3:0] lstate;
  logic upd_valid, line_we, use_temp;
  logic [1:0] upd_way;
  logic [3:0] upd_state;
  logic [31:0] upd_addr, ready_time, cycle_now;
  logic [LB-1:0] line_data;

  int total = 0;
  int bad = 0;
  logic [31:0] issue_t;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fill_state_unit dut_i (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid),
    .rsp_has_data(has_data), .rsp_is_read(is_read), .rsp_sharers(sharers),
    .rsp_peer_supplied(peer), .rsp_invalidate(inval), .rsp_clean(clean),
    .rsp_error(err), .rsp_bytes(bytes), .rsp_addr(addr), .rsp_data(data),
    .rsp_hdr_dly(hdr), .rsp_pay_dly(pay), .alloc_req(alloc),
    .lookup_hit(hit), .lookup_way(lway), .lookup_state(lstate),
    .victim_ok(vok), .victim_way(vway), .upd_valid(upd_valid),
    .upd_way(upd_way), .upd_state(upd_state), .upd_addr(upd_addr),
    .line_we(line_we), .line_data(line_data), .use_temp(use_temp),
    .ready_time(ready_time), .cycle_now(cycle_now)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_rsp();
    fill_valid = 0; has_data = 0; is_read = 0; sharers = 0; peer = 0;
    inval = 0; clean = 0; err = 0; bytes = 0; addr = 0; data = '0;
    hdr = 0; pay = 0; alloc = 0; hit = 0; lway = 0; vway = 0;
    lstate = 0; vok = 0;
  endtask

  task automatic read_setup(logic [31:0] a);
    clear_rsp();
    is_read = 1; has_data = 1; bytes = 6'd32; addr = a;
    data = {8{a}};
  endtask

  // present response on a falling edge, result is checked one cycle later
  task automatic fire();
    fill_valid = 1;
    issue_t = cycle_now;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 upd_valid", upd_valid, 0);
    chk("R1 line_we", line_we, 0);
    chk("R1 use_temp", use_temp, 0);
    chk("R1 cycle_now", cycle_now, 0);
  endtask

  task automatic t_exclusive();
    read_setup(32'h0000_1234); alloc = 1; vok = 1; vway = 2'd2;
    hdr = 8'd3; pay = 8'd4;
    fire();
    chk("R13 valid", upd_valid, 1);
    chk("R2 R3 exclusive state", upd_state, 4'b1110);
    chk("R5 victim way", upd_way, 2);
    chk("R5 no temp", use_temp, 0);
    chk("R8 write", line_we, 1);
    chk("R8 data", line_data == {8{32'h0000_1234}}, 1);
    chk("R9 ready", ready_time, issue_t + 2 + 3 + 4);
    chk("R14 addr", upd_addr, 32'h0000_1220);
    clear_rsp();
    @(negedge clk);
    chk("R13 pulse ends", upd_valid, 0);
  endtask

  task automatic t_modified();
    read_setup(32'h40); alloc = 1; vok = 1; vway = 1; peer = 1;
    fire();
    chk("R3 modified", upd_state, 4'b1111);
    chk("R5 way", upd_way, 1);
  endtask

  task automatic t_shared();
    read_setup(32'h80); alloc = 1; vok = 1; sharers = 1; peer = 1;
    fire();
    chk("R4 shared ignores peer", upd_state, 4'b1100);
    read_setup(32'h80); alloc = 1; vok = 1; sharers = 1;
    fire();
    chk("R4 shared", upd_state, 4'b1100);
  endtask

  task automatic t_temp();
    read_setup(32'hC0);
    fire();
    chk("R6 no alloc temp", use_temp, 1);
    chk("R6 state", upd_state, 4'b1110);
    chk("R6 write to temp", line_we, 1);
    read_setup(32'hC0); alloc = 1; vok = 0;
    fire();
    chk("R6 no victim temp", use_temp, 1);
  endtask

  task automatic t_hit();
    clear_rsp(); hit = 1; lway = 3; lstate = 4'b1101;
    fire();
    chk("R7 upgrade keeps dirty", upd_state, 4'b1111);
    chk("R7 hit way", upd_way, 3);
    chk("R7 no temp", use_temp, 0);
    chk("R7 no write", line_we, 0);
    clear_rsp(); hit = 1; lway = 2; lstate = 4'b1101; sharers = 1;
    fire();
    chk("R7 dirty kept with sharers", upd_state, 4'b1101);
  endtask

  task automatic t_badsize();
    read_setup(32'h100); alloc = 1; vok = 1; bytes = 6'd16;
    fire();
    chk("R8 short read no write", line_we, 0);
    chk("R8 short read state", upd_state, 0);
    chk("R8 short read no temp", use_temp, 0);
  endtask

  task automatic t_error();
    read_setup(32'h140); err = 1; hit = 1; lway = 1; lstate = 4'b1010;
    fire();
    chk("R11 error no write", line_we, 0);
    chk("R11 error keeps state", upd_state, 4'b1010);
    read_setup(32'h140); err = 1;
    fire();
    chk("R11 error miss no temp", use_temp, 0);
    chk("R11 error miss state", upd_state, 0);
  endtask

  task automatic t_clean();
    clear_rsp(); clean = 1; hit = 1; lway = 2; lstate = 4'b1010;
    fire();
    chk("R10 restore readable", upd_state, 4'b1110);
    chk("R10 no write", line_we, 0);
    clear_rsp(); clean = 1; alloc = 1; vok = 1;
    fire();
    chk("R10 miss state", upd_state, 0);
    chk("R10 miss no temp", use_temp, 0);
  endtask

  task automatic t_inval();
    clear_rsp(); inval = 1; alloc = 1; vok = 1; vway = 3; addr = 32'h1FF;
    fire();
    chk("R12 writable line", upd_state, 4'b1110);
    chk("R12 no data write", line_we, 0);
    chk("R12 victim", upd_way, 3);
    chk("R14 addr", upd_addr, 32'h1E0);
  endtask

  task automatic t_ready();
    read_setup(32'h200); alloc = 1; vok = 1; hdr = 8'd255; pay = 8'd255;
    fire();
    chk("R9 max delays", ready_time, issue_t + 2 + 255 + 255);
    read_setup(32'h200); alloc = 1; vok = 1;
    fire();
    chk("R9 zero delays", ready_time, issue_t + 2);
  endtask

  task automatic t_back_to_back();
    read_setup(32'h300); alloc = 1; vok = 1; vway = 0;
    fill_valid = 1;
    @(negedge clk);
    chk("R13 first", upd_valid, 1);
    sharers = 1;
    @(negedge clk);
    fill_valid = 0;
    chk("R13 second", upd_valid, 1);
    chk("R4 second shared", upd_state, 4'b1100);
    @(negedge clk);
    chk("R13 idle", upd_valid, 0);
  endtask

  initial begin
    clear_rsp();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_exclusive();
    t_modified();
    t_shared();
    t_temp();
    t_hit();
    t_badsize();
    t_error();
    t_clean();
    t_inval();
    t_ready();
    t_back_to_back();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule